// File: doc/BRIEF.md
# Auto-Reload Tick Timer with Fractional Period Correction

This block is a general-purpose up-counting timer with a small register file. The counter advances by one on each cycle where the slow functional clock enable `tick_en` is high and the start bit is set. When it steps past all-ones it overflows. It then either reloads from the load register (auto-reload on) or wraps to zero, and it raises a sticky overflow flag that drives the `irq` output. To get a period of N ticks, software writes the load register with 2^32 - N and preloads the counter with the same value.

A tick source such as 32768 Hz does not divide into a 1 ms period. For that case the timer carries a signed error accumulator. Software programs two correction values: a positive one for a long period of N+1 ticks and a negative one for a short period of N ticks. At every overflow the accumulator adds the value that belongs to the period that has just ended. When its sign then shows a deficit, the next period is stretched by one tick, because the counter holds at all-ones for one extra tick. The average period is then exact. With both correction values at zero the timer behaves as a plain reload timer.

A soft reset, started through the configuration register, clears the whole block for a fixed number of cycles and reports completion through a done bit. The control register also stores the compare-enable, output-level, capture-edge, trigger and pulse/toggle fields for the neighbouring output logic. Each of these fields keeps its bit position.

Top module: `gp_tick_timer`

## Requirements
- R1: After reset `irq` is 0 and every register reads 0, except the configuration register, which reads 1 (done bit 0 set). `rd_data` shows the register selected by `rd_addr` one cycle later. Addresses: 0 config, 1 control, 2 counter, 3 load, 4 status, 5 positive correction, 6 negative correction; address 7 reads 0.
- R2: The counter increments by exactly one on each cycle with `tick_en` high while control bit 0 (start) is 1. With start at 0 it holds its value.
- R3: On a tick with the counter at all-ones (and no stretch pending), the counter takes the load value if control bit 1 (auto-reload) is 1 and 0 otherwise. With load and counter both at 2^32 - N, overflow comes after exactly N ticks.
- R4: The overflow flag (status bit 1, mirrored on `irq`) is set in the same edge as the reload. A set beats a same-cycle clear, and the flag stays set until it is cleared.
- R5: Writing status with bit 1 set clears the flag. Writing status with bit 1 clear leaves it unchanged.
- R6: The correction accumulator starts at 0 with the stretch off. At each overflow it adds the positive value if the finished period was stretched and the negative value otherwise. The next period is stretched by one tick exactly when the new sum is negative. With N = 32, +232000 and -768000, the periods after the first overflow are 33, 33, 33, 33, 32, and 125 periods take 4096 ticks in total.
- R7: Writing the config register with bit 1 set clears all registers, the counter, the flag and the accumulator. For the next RST_CYCLES cycles the done bit reads 0 and writes are ignored; after that it reads 1.
- R8: Control bits 0, 1, 6, 7 and 13:8 are stored and read back; all other control bits read 0.
- R9: A counter write loads the written value and discards that cycle's tick; no overflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Functional clock enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, one cycle after `rd_addr` |
| irq | output | 1 | Sticky overflow interrupt |

## Verification
The counter is driven with ticks stopped, ticks with start cleared, bursts of an exact length and continuous ticks. Together these separate gating by start from gating by `tick_en` and show off-by-one errors in overflow timing. Reload and wrap are told apart by running the same all-ones overflow with auto-reload on and off. Collisions are exercised on purpose: a counter write on a tick, a status clear in the overflow cycle, and writes during a soft reset. The correction path runs at the 32768 Hz / 1 ms setting, so the pattern of stretched periods and the exact 4096-tick total over 125 periods expose a wrong sign test or a wrong choice of correction value.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 14;

  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_POS   = 3'd5;
  localparam logic [ADDR_W-1:0] A_NEG   = 3'd6;

  localparam int B_START = 0;
  localparam int B_AUTO  = 1;
  localparam int B_SRST  = 1;
  localparam int B_OVF   = 1;

  // writable control bits: 13..6, 1, 0
  localparam logic [CTRL_W-1:0] CTRL_MASK = 14'b11111111000011;
endpackage

// File: rtl/gtt_srst.sv
module gtt_srst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (left_q != '0)  left_q <= left_q - CW'(1);
    else if (go_i)          left_q <= CW'(RST_CYCLES);
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/gtt_counter.sv
module gtt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         ld_en_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         auto_i,
  input  logic [W-1:0] reload_i,
  input  logic         stretch_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         held_q;
  logic         step, at_max, hold;

  assign step   = run_i && !ld_en_i;
  assign at_max = &cnt_q;
  assign ovf_o  = step && at_max && (!stretch_i || held_q);
  assign hold   = step && at_max && stretch_i && !held_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (ld_en_i) begin
      cnt_q  <= ld_val_i;
      held_q <= 1'b0;
    end else if (ovf_o) begin
      cnt_q  <= auto_i ? reload_i : '0;
      held_q <= 1'b0;
    end else if (hold) begin
      held_q <= 1'b1;
    end else if (step) begin
      cnt_q  <= cnt_q + W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gtt_corr.sv
module gtt_corr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         ovf_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  output logic         long_o
);
  logic signed [W-1:0] acc_q;
  logic signed [W-1:0] sum;
  logic                long_q;

  assign sum = acc_q + $signed(long_q ? pos_i : neg_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_q  <= '0;
      long_q <= 1'b0;
    end else if (ovf_i) begin
      acc_q  <= sum;
      long_q <= sum[W-1];
    end
  end

  assign long_o = long_q;
endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
  import gtt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int W = DATA_W;

  logic              busy, srst_go, clear_all, wr_ok;
  logic              cnt_wr, stat_clr, ovf, long_per;
  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      load_q, pos_q, neg_q, cnt;
  logic              flag_q;
  logic [W-1:0]      rd_q;

  assign wr_ok     = wr_en && !busy;
  assign srst_go   = wr_ok && (wr_addr == A_CFG) && wr_data[B_SRST];
  assign clear_all = busy || srst_go;
  assign cnt_wr    = wr_ok && (wr_addr == A_COUNT);
  assign stat_clr  = wr_ok && (wr_addr == A_STAT) && wr_data[B_OVF];

  gtt_srst #(.RST_CYCLES(RST_CYCLES)) srst_i (
    .clk(clk), .rst(rst), .go_i(srst_go), .busy_o(busy)
  );

  gtt_counter #(.W(W)) cnt_i (
    .clk(clk), .rst(rst), .clear_i(clear_all),
    .run_i(ctrl_q[B_START] && tick_en),
    .ld_en_i(cnt_wr), .ld_val_i(wr_data),
    .auto_i(ctrl_q[B_AUTO]), .reload_i(load_q),
    .stretch_i(long_per), .cnt_o(cnt), .ovf_o(ovf)
  );

  gtt_corr #(.W(W)) corr_i (
    .clk(clk), .rst(rst), .clear_i(clear_all), .ovf_i(ovf),
    .pos_i(pos_q), .neg_i(neg_q), .long_o(long_per)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      ctrl_q <= '0;
      load_q <= '0;
      pos_q  <= '0;
      neg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ok && wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_MASK;
      if (wr_ok && wr_addr == A_LOAD) load_q <= wr_data;
      if (wr_ok && wr_addr == A_POS)  pos_q  <= wr_data;
      if (wr_ok && wr_addr == A_NEG)  neg_q  <= wr_data;
      if (ovf)           flag_q <= 1'b1;
      else if (stat_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        A_CFG:   rd_q <= W'(!busy);
        A_CTRL:  rd_q <= W'(ctrl_q);
        A_COUNT: rd_q <= cnt;
        A_LOAD:  rd_q <= load_q;
        A_STAT:  rd_q <= W'({flag_q, 1'b0});
        A_POS:   rd_q <= pos_q;
        A_NEG:   rd_q <= neg_q;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = flag_q;
endmodule

// File: rtl/gtt_checker.sv
module gtt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         ovf,
  input logic         clr,
  input logic         flag,
  input logic         start,
  input logic         auto_rl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] load,
  input logic         ld_en,
  input logic         stat_clr
);
  assert_flag_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(ovf));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> flag);

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf && auto_rl && !clr) |=> (cnt == $past(load)));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!start && !ld_en && !clr) |=> $stable(cnt));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !ovf && !clr) |=> !flag);

  assert_srst_clears_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cnt == '0 && !flag));
endmodule

bind gp_tick_timer gtt_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .ovf(ovf), .clr(clear_all),
  .flag(flag_q), .start(ctrl_q[0]), .auto_rl(ctrl_q[1]), .cnt(cnt),
  .load(load_q), .ld_en(cnt_wr), .stat_clr(stat_clr)
);

// File: tb/gp_tick_timer_tb_top.sv
module gp_tick_timer_tb_top;
  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  gp_tick_timer #(.DATA_W(32), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [31:0] m_cnt, m_load, m_rd;
  logic [13:0] m_ctrl;
  int          m_pos, m_neg, m_acc, m_left;
  bit          m_flag, m_long, m_extra;

  task automatic m_clear();
    m_cnt = 0; m_load = 0; m_ctrl = 0; m_pos = 0; m_neg = 0;
    m_acc = 0; m_flag = 0; m_long = 0; m_extra = 0;
  endtask

  always @(posedge clk) begin
    bit cnt_w, adv, ov;
    if (rst) begin
      m_clear(); m_left = 0; m_rd = 0;
    end else begin
      case (rd_addr)
        3'd0: m_rd = (m_left == 0) ? 32'd1 : 32'd0;
        3'd1: m_rd = {18'd0, m_ctrl};
        3'd2: m_rd = m_cnt;
        3'd3: m_rd = m_load;
        3'd4: m_rd = m_flag ? 32'd2 : 32'd0;
        3'd5: m_rd = m_pos;
        3'd6: m_rd = m_neg;
        default: m_rd = 0;
      endcase
      if (m_left > 0) begin
        m_left--; m_clear();
      end else if (wr_en && wr_addr == 3'd0 && wr_data[1]) begin
        m_clear(); m_left = RSTC;
      end else begin
        cnt_w = wr_en && wr_addr == 3'd2;
        adv = m_ctrl[0] && tick_en && !cnt_w;
        ov = 0;
        if (cnt_w) begin m_cnt = wr_data; m_extra = 0; end
        else if (adv) begin
          if (m_cnt != 32'hFFFF_FFFF) m_cnt = m_cnt + 1;
          else if (m_long && !m_extra) m_extra = 1;
          else begin
            ov = 1; m_extra = 0;
            m_cnt = m_ctrl[1] ? m_load : 32'd0;
          end
        end
        if (ov) begin
          m_acc = m_acc + (m_long ? m_pos : m_neg);
          m_long = (m_acc < 0);
        end
        if (ov) m_flag = 1;
        else if (wr_en && wr_addr == 3'd4 && wr_data[1]) m_flag = 0;
        if (wr_en && wr_addr == 3'd1) m_ctrl = wr_data[13:0] & 14'b11111111000011;
        if (wr_en && wr_addr == 3'd3) m_load = wr_data;
        if (wr_en && wr_addr == 3'd5) m_pos = wr_data;
        if (wr_en && wr_addr == 3'd6) m_neg = wr_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R8";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5, 3'd6: return "R6";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk({"R4 irq model"}, {31'd0, irq}, {31'd0, m_flag});
      chk({addr_tag(rd_addr), " rd_data model"}, rd_data, m_rd);
    end
  end

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_up();
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic tick_n(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    int nrise, cyc, last, first;
    int per[6];
    repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;

    // R1 reset values
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk(3'd0, 32'd1, "R1 cfg done");
    rd_chk(3'd1, 32'd0, "R1 ctrl");
    rd_chk(3'd2, 32'd0, "R1 count");
    rd_chk(3'd3, 32'd0, "R1 load");
    rd_chk(3'd4, 32'd0, "R1 status");
    rd_chk(3'd5, 32'd0, "R1 pos");
    rd_chk(3'd6, 32'd0, "R1 neg");
    rd_chk(3'd7, 32'd0, "R1 unused addr");

    // R8 control fields
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'h0000_3FC3, "R8 ctrl mask");
    wr_reg(3'd1, 32'h0000_0A40);
    rd_chk(3'd1, 32'h0000_0A40, "R8 capture/trigger");
    wr_reg(3'd1, 32'h0);

    // R2 gating and counting
    wr_reg(3'd2, 32'd100);
    tick_n(10);
    rd_chk(3'd2, 32'd100, "R2 stopped");
    wr_reg(3'd1, 32'd1);
    tick_n(10);
    rd_chk(3'd2, 32'd110, "R2 ten ticks");

    // R9 counter write beats tick
    tick_en = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 32'd5;
    @(negedge clk); wr_en = 0; tick_en = 0;
    rd_chk(3'd2, 32'd5, "R9 write wins");

    // R3 wrap without auto-reload, R4 flag
    wr_reg(3'd2, 32'hFFFF_FFFE);
    tick_n(2);
    chk("R4 irq on overflow", {31'd0, irq}, 32'd1);
    rd_chk(3'd2, 32'd0, "R3 wrap to zero");
    rd_chk(3'd4, 32'd2, "R4 status bit");

    // R5 write-1-to-clear
    wr_reg(3'd4, 32'd0);
    chk("R5 write 0 keeps flag", {31'd0, irq}, 32'd1);
    wr_reg(3'd4, 32'd2);
    chk("R5 write 1 clears", {31'd0, irq}, 32'd0);

    // R3 auto-reload period N=10
    wr_reg(3'd3, 32'hFFFF_FFF6);
    wr_reg(3'd2, 32'hFFFF_FFF6);
    wr_reg(3'd1, 32'd3);
    tick_n(9);
    chk("R3 no overflow at N-1", {31'd0, irq}, 32'd0);
    tick_n(1);
    chk("R3 overflow at N", {31'd0, irq}, 32'd1);
    rd_chk(3'd2, 32'hFFFF_FFF6, "R3 reload value");

    // R4 set beats clear
    wr_reg(3'd4, 32'd2);
    wr_reg(3'd2, 32'hFFFF_FFFF);
    tick_en = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 32'd2;
    @(negedge clk); wr_en = 0; tick_en = 0;
    chk("R4 set wins", {31'd0, irq}, 32'd1);

    // R6 correction, 32768 Hz to 1 ms
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd3, 32'hFFFF_FFE0);
    wr_reg(3'd2, 32'hFFFF_FFE0);
    wr_reg(3'd5, 32'((32768/1000 + 1) * 1000000 - 32768000 * (1000/1000)));
    wr_reg(3'd6, 32'((32768/1000) * 1000000 - 32768000 * (1000/1000)));
    wr_reg(3'd4, 32'd2);
    wr_reg(3'd1, 32'd3);
    tick_en = 1;
    nrise = 0; cyc = 0; last = 0; first = 0;
    while (nrise < 126) begin
      @(negedge clk);
      cyc++;
      if (irq) begin
        nrise++;
        if (nrise == 1) first = cyc;
        else if (nrise <= 6) per[nrise-2] = cyc - last;
        last = cyc;
        wr_en = 1; wr_addr = 3'd4; wr_data = 32'd2;
      end else wr_en = 0;
    end
    @(negedge clk); wr_en = 0; tick_en = 0;
    chk("R6 period 1", per[0], 32'd33);
    chk("R6 period 2", per[1], 32'd33);
    chk("R6 period 3", per[2], 32'd33);
    chk("R6 period 4", per[3], 32'd33);
    chk("R6 period 5", per[4], 32'd32);
    chk("R6 125 periods", last - first, 32'd4096);

    // R7 soft reset
    wr_reg(3'd0, 32'd2);
    wr_en = 1; wr_addr = 3'd3; wr_data = 32'h1234; rd_addr = 3'd0;
    @(negedge clk); wr_en = 0;
    chk("R7 done low while busy", rd_data, 32'd0);
    repeat (8) @(negedge clk);
    rd_chk(3'd0, 32'd1, "R7 done after reset");
    rd_chk(3'd3, 32'd0, "R7 load cleared, write ignored");
    rd_chk(3'd1, 32'd0, "R7 ctrl cleared");
    rd_chk(3'd5, 32'd0, "R7 pos cleared");
    rd_chk(3'd2, 32'd0, "R7 count cleared");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule